// File: doc/BRIEF.md
# Multi-mode position counter

The block keeps a 24-bit signed position from count pulses that arrive with a direction bit, typically from an upstream quadrature or step/direction decoder. A preset register, written one byte at a time, gives the value that a load command copies into the counter. In the limited modes the same register holds the count limit, and in every mode it holds the compare value. A snapshot latch captures the counter on request and is read back one byte at a time, so counting is never stalled to read the position.

Four count modes shape how the counter behaves at its limits: free wrap, stop after one wrap, hold at zero and the preset, or divide by preset plus one. Carry, borrow, compare and index events are kept as sticky status bits. A configurable active-low event flag shows those bits either latched or as one-cycle pulses. A second flag shows the sign or the direction. The index input, with selectable active level, can load, clear or snapshot the counter on its active edge. Configuration arrives on static inputs from a register block elsewhere. Bus decoding and interrupt aggregation belong to neighbouring blocks.

Top module: `pos_counter`

## Requirements
- R1: After reset the counter, sign, direction and sticky status are zero, status reads 0x10 (counting enabled), and both flags are high.
- R2: A preset write stores `preset_data_i` into byte `preset_byte_i` (0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16). The load command copies the preset into the counter. The latch command copies the counter value from before this cycle's update into the snapshot, which `latch_byte_i` reads with the same byte mapping. The count is not disturbed by the copy.
- R3: In mode 00 (free run) the counter wraps. Up from 0xFFFFFF sets carry (status bit 0) and clears sign (status bit 6). Down from 0 sets borrow (bit 1) and sets sign. The clear command also clears sign.
- R4: In modes 00 and 01, a count whose result equals the preset sets compare (status bit 2) in either direction.
- R5: In mode 01 (single cycle), a carry or a borrow stops counting and clears status bit 4. A load or a clear of the counter restarts counting.
- R6: In mode 10 (range limit), counting up holds at the preset and counting down holds at 0. Compare is set when an up count results in the preset, and borrow is set when a down count results in 0. The opposite direction resumes counting at once.
- R7: In mode 11 (modulo-n), an up count at the preset gives 0 and sets compare. A down count at 0 gives the preset and sets borrow.
- R8: Status is {0, sign, direction up, counting enabled, index, compare, borrow, carry} from bit 7 to bit 0. Event-select bits 0..3 route carry, borrow, compare and index to the active-low event flag. With `cfg_flag_pulse_i`=0 the flag stays low while a selected sticky bit is set. With `cfg_flag_pulse_i`=1 the flag is low for one cycle per event. The clear-status command zeroes bits 3:0, and an event in the same cycle still sets its bit.
- R9: In modes 10 and 11, compare and borrow reach the event flag only as one-cycle pulses, whatever `cfg_flag_pulse_i` is set to.
- R10: `cfg_flagb_sel_i` 01 drives the second flag with the sign, and 10 drives it with the direction (high = up). 00 and 11 hold it high.
- R11: The active edge of the index input (`cfg_idx_pol_i`=1 means high is active) sets status bit 3. Index function 01 loads the counter, 10 clears it, 11 snapshots it and 00 does nothing more. A level held active acts only once.
- R12: `cfg_cnt_dis_i` freezes the counter and clears status bit 4.
- R13: In one cycle, clear beats load, and load beats a count pulse, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_pulse_i | input | 1 | One count this cycle |
| cnt_up_i | input | 1 | Direction of the count, 1 = up |
| index_i | input | 1 | Qualified index level |
| cfg_mode_i | input | 2 | Count mode |
| cfg_idx_fn_i | input | 2 | Index function |
| cfg_idx_pol_i | input | 1 | Index active level, 1 = high |
| cfg_flag_sel_i | input | 4 | Event flag sources {index, compare, borrow, carry} |
| cfg_flag_pulse_i | input | 1 | Event flag pulses instead of latching |
| cfg_flagb_sel_i | input | 2 | Second flag source |
| cfg_cnt_dis_i | input | 1 | Freeze counting |
| cmd_clr_cnt_i | input | 1 | Clear counter and sign |
| cmd_load_cnt_i | input | 1 | Load counter from preset |
| cmd_latch_i | input | 1 | Snapshot counter |
| cmd_clr_status_i | input | 1 | Clear sticky status |
| preset_we_i | input | 1 | Preset byte write strobe |
| preset_byte_i | input | 2 | Preset byte index |
| preset_data_i | input | 8 | Preset byte data |
| latch_byte_i | input | 2 | Snapshot byte index |
| latch_data_o | output | 8 | Snapshot byte |
| status_o | output | 8 | Status word |
| flag_a_o | output | 1 | Event flag, active low |
| flag_b_o | output | 1 | Sign or direction flag |

## Verification
The hardest state to reach from the ports is the counter sitting at a mode limit with a count pulse arriving. Examples are 0xFFFFFF in single-cycle mode, or the preset value in range-limit or modulo-n mode while the event flag is configured as latched. The stimulus writes a preset close to the limit byte by byte and loads it, or clears the counter and steps it a few pulses. It then checks that the flag pulses for exactly one cycle, and reads the count back through the snapshot latch to confirm the hold, the wrap or the stop.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_RANGE  = 2'b10,
    MODE_MODN   = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    IDX_OFF   = 2'b00,
    IDX_LOAD  = 2'b01,
    IDX_CLEAR = 2'b10,
    IDX_LATCH = 2'b11
  } idx_fn_e;

  typedef enum logic [1:0] {
    FB_HIGH = 2'b00,
    FB_SIGN = 2'b01,
    FB_DIR  = 2'b10,
    FB_RSVD = 2'b11
  } flagb_sel_e;

  typedef struct packed {
    logic idx;
    logic cmp;
    logic bw;
    logic cy;
  } evt_t;
endpackage

// File: rtl/pc_byte_regs.sv
module pc_byte_regs #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W,
  localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              latch_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [CNT_W-1:0]  preset_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [CNT_W-1:0] preset_q, snap_q;

  for (genvar g = 0; g < NB; g++) begin : g_pbyte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        preset_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(g))
        preset_q[g*BYTE_W +: BYTE_W] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         snap_q <= '0;
    else if (latch_en_i) snap_q <= cnt_i;
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NB; b++)
      if (rd_sel_i == SEL_W'(b)) rd_data_o = snap_q[b*BYTE_W +: BYTE_W];
  end

  assign preset_o = preset_q;
endmodule

// File: rtl/pc_count_core.sv
module pc_count_core
  import pc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_mode_e        mode_i,
  input  logic             pulse_i,
  input  logic             up_i,
  input  logic             dis_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sign_o,
  output logic             dir_o,
  output logic             cen_o,
  output evt_t             evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             sign_q, dir_q, halt_q;
  logic             cen;
  evt_t             ev;

  assign cen = !dis_i && !halt_q;

  always_comb begin
    cnt_nxt = cnt_q;
    ev      = '0;
    if (cen && pulse_i) begin
      unique case (mode_i)
        MODE_RANGE: begin
          if (up_i) begin
            if (cnt_q != preset_i) cnt_nxt = cnt_q + 1'b1;
            ev.cmp = (cnt_nxt == preset_i);
          end else begin
            if (cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
            ev.bw = (cnt_nxt == '0);
          end
        end
        MODE_MODN: begin
          if (up_i) begin
            if (cnt_q == preset_i) begin
              cnt_nxt = '0;
              ev.cmp  = 1'b1;
            end else cnt_nxt = cnt_q + 1'b1;
          end else begin
            if (cnt_q == '0) begin
              cnt_nxt = preset_i;
              ev.bw   = 1'b1;
            end else cnt_nxt = cnt_q - 1'b1;
          end
        end
        default: begin
          if (up_i) begin
            cnt_nxt = cnt_q + 1'b1;
            ev.cy   = (cnt_q == CNT_MAX);
          end else begin
            cnt_nxt = cnt_q - 1'b1;
            ev.bw   = (cnt_q == '0);
          end
          ev.cmp = (cnt_nxt == preset_i);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sign_q <= 1'b0;
      dir_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (pulse_i) dir_q <= up_i;
      if (clr_i) begin
        cnt_q  <= '0;
        sign_q <= 1'b0;
        halt_q <= 1'b0;
      end else if (load_i) begin
        cnt_q  <= preset_i;
        halt_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nxt;
        if (mode_i == MODE_FREE || mode_i == MODE_SINGLE) begin
          if (ev.bw) sign_q <= 1'b1;
          if (ev.cy) sign_q <= 1'b0;
        end
        if (mode_i == MODE_SINGLE && (ev.cy || ev.bw)) halt_q <= 1'b1;
      end
    end
  end

  // command wins over the pulse: no event from a dropped count
  assign evt_o  = (clr_i || load_i) ? '0 : ev;
  assign cnt_o  = cnt_q;
  assign sign_o = sign_q;
  assign dir_o  = dir_q;
  assign cen_o  = cen;
endmodule

// File: rtl/pc_flags.sv
module pc_flags
  import pc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  evt_t       evt_i,
  input  logic       clr_i,
  input  logic [3:0] sel_i,
  input  logic       pulse_mode_i,
  input  logic       limit_mode_i,
  input  flagb_sel_e flagb_sel_i,
  input  logic       sign_i,
  input  logic       dir_i,
  output logic [3:0] sticky_o,
  output logic       flag_a_o,
  output logic       flag_b_o
);
  logic [3:0] sticky_q, evt_q, lat_mask;
  logic       lat_hit, pls_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      evt_q    <= '0;
    end else begin
      sticky_q <= (clr_i ? 4'b0000 : sticky_q) | evt_i;
      evt_q    <= evt_i;
    end
  end

  // limit modes: compare and borrow never latch on the flag
  assign lat_mask = limit_mode_i ? 4'b1001 : 4'b1111;
  assign lat_hit  = !pulse_mode_i && |(sticky_q & sel_i & lat_mask);
  assign pls_hit  = |(evt_q & sel_i & (pulse_mode_i ? 4'b1111 : ~lat_mask));
  assign flag_a_o = !(lat_hit || pls_hit);

  always_comb begin
    unique case (flagb_sel_i)
      FB_SIGN: flag_b_o = sign_i;
      FB_DIR:  flag_b_o = dir_i;
      default: flag_b_o = 1'b1;
    endcase
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/pos_counter.sv
module pos_counter
  import pc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W,
  localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_pulse_i,
  input  logic              cnt_up_i,
  input  logic              index_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [1:0]        cfg_idx_fn_i,
  input  logic              cfg_idx_pol_i,
  input  logic [3:0]        cfg_flag_sel_i,
  input  logic              cfg_flag_pulse_i,
  input  logic [1:0]        cfg_flagb_sel_i,
  input  logic              cfg_cnt_dis_i,
  input  logic              cmd_clr_cnt_i,
  input  logic              cmd_load_cnt_i,
  input  logic              cmd_latch_i,
  input  logic              cmd_clr_status_i,
  input  logic              preset_we_i,
  input  logic [SEL_W-1:0]  preset_byte_i,
  input  logic [BYTE_W-1:0] preset_data_i,
  input  logic [SEL_W-1:0]  latch_byte_i,
  output logic [BYTE_W-1:0] latch_data_o,
  output logic [7:0]        status_o,
  output logic              flag_a_o,
  output logic              flag_b_o
);
  cnt_mode_e        mode;
  idx_fn_e          idx_fn;
  logic             idx_act, idx_act_q, idx_edge;
  logic             do_clr, do_load, do_latch;
  logic [CNT_W-1:0] cnt_w, preset_w;
  logic             sign_w, dir_w, cen_w;
  evt_t             core_evt, all_evt;
  logic [3:0]       sticky_w;

  assign mode   = cnt_mode_e'(cfg_mode_i);
  assign idx_fn = idx_fn_e'(cfg_idx_fn_i);

  assign idx_act = cfg_idx_pol_i ? index_i : !index_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_act_q <= 1'b1;
    else         idx_act_q <= idx_act;
  end
  assign idx_edge = idx_act && !idx_act_q;

  assign do_clr   = cmd_clr_cnt_i  || (idx_edge && idx_fn == IDX_CLEAR);
  assign do_load  = cmd_load_cnt_i || (idx_edge && idx_fn == IDX_LOAD);
  assign do_latch = cmd_latch_i    || (idx_edge && idx_fn == IDX_LATCH);

  pc_byte_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (preset_we_i),
    .wr_sel_i   (preset_byte_i),
    .wr_data_i  (preset_data_i),
    .latch_en_i (do_latch),
    .cnt_i      (cnt_w),
    .rd_sel_i   (latch_byte_i),
    .preset_o   (preset_w),
    .rd_data_o  (latch_data_o)
  );

  pc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .pulse_i  (cnt_pulse_i),
    .up_i     (cnt_up_i),
    .dis_i    (cfg_cnt_dis_i),
    .clr_i    (do_clr),
    .load_i   (do_load),
    .preset_i (preset_w),
    .cnt_o    (cnt_w),
    .sign_o   (sign_w),
    .dir_o    (dir_w),
    .cen_o    (cen_w),
    .evt_o    (core_evt)
  );

  always_comb begin
    all_evt     = core_evt;
    all_evt.idx = idx_edge;
  end

  pc_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (all_evt),
    .clr_i        (cmd_clr_status_i),
    .sel_i        (cfg_flag_sel_i),
    .pulse_mode_i (cfg_flag_pulse_i),
    .limit_mode_i (mode == MODE_RANGE || mode == MODE_MODN),
    .flagb_sel_i  (flagb_sel_e'(cfg_flagb_sel_i)),
    .sign_i       (sign_w),
    .dir_i        (dir_w),
    .sticky_o     (sticky_w),
    .flag_a_o     (flag_a_o),
    .flag_b_o     (flag_b_o)
  );

  assign status_o = {1'b0, sign_w, dir_w, cen_w, sticky_w};
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_pulse_i,
  input logic             cnt_up_i,
  input logic             index_i,
  input logic [1:0]       cfg_mode_i,
  input logic [1:0]       cfg_idx_fn_i,
  input logic             cfg_idx_pol_i,
  input logic [1:0]       cfg_flagb_sel_i,
  input logic             cfg_cnt_dis_i,
  input logic             cmd_clr_cnt_i,
  input logic             cmd_load_cnt_i,
  input logic             cmd_clr_status_i,
  input logic [7:0]       status_o,
  input logic             flag_b_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] preset_i
);
  logic quiet;
  assign quiet = !cmd_clr_cnt_i && !cmd_load_cnt_i && cfg_idx_fn_i == 2'b00;

  assert_sign_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_clr_cnt_i |=> !status_o[6]);

  assert_single_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == 2'b01 && quiet && cnt_pulse_i && cnt_up_i && status_o[4] && cnt_i == '1)
    |=> !status_o[4]);

  assert_range_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == 2'b10 && quiet && cnt_pulse_i && cnt_up_i && cnt_i == preset_i)
    |=> $stable(cnt_i));

  assert_modn_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == 2'b11 && quiet && cnt_pulse_i && cnt_up_i && status_o[4] && cnt_i == preset_i)
    |=> cnt_i == '0);

  assert_status_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_clr_status_i && !cnt_pulse_i && $stable(index_i) && $stable(cfg_idx_pol_i))
    |=> status_o[3:0] == 4'b0000);

  assert_flagb_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_flagb_sel_i == 2'b00 || cfg_flagb_sel_i == 2'b11) |-> flag_b_o);

  assert_freeze_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_cnt_dis_i && quiet) |=> $stable(cnt_i));
endmodule

bind pos_counter pc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cnt_pulse_i      (cnt_pulse_i),
  .cnt_up_i         (cnt_up_i),
  .index_i          (index_i),
  .cfg_mode_i       (cfg_mode_i),
  .cfg_idx_fn_i     (cfg_idx_fn_i),
  .cfg_idx_pol_i    (cfg_idx_pol_i),
  .cfg_flagb_sel_i  (cfg_flagb_sel_i),
  .cfg_cnt_dis_i    (cfg_cnt_dis_i),
  .cmd_clr_cnt_i    (cmd_clr_cnt_i),
  .cmd_load_cnt_i   (cmd_load_cnt_i),
  .cmd_clr_status_i (cmd_clr_status_i),
  .status_o         (status_o),
  .flag_b_o         (flag_b_o),
  .cnt_i            (cnt_w),
  .preset_i         (preset_w)
);

// File: tb/pos_counter_tb.sv
module pos_counter_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_pulse_i = 0, cnt_up_i = 0, index_i = 0;
  logic [1:0] cfg_mode_i = 0, cfg_idx_fn_i = 0, cfg_flagb_sel_i = 0;
  logic       cfg_idx_pol_i = 1, cfg_flag_pulse_i = 0, cfg_cnt_dis_i = 0;
  logic [3:0] cfg_flag_sel_i = 0;
  logic       cmd_clr_cnt_i = 0, cmd_load_cnt_i = 0, cmd_latch_i = 0, cmd_clr_status_i = 0;
  logic       preset_we_i = 0;
  logic [1:0] preset_byte_i = 0, latch_byte_i = 0;
  logic [7:0] preset_data_i = 0;
  logic [7:0] latch_data_o, status_o;
  logic       flag_a_o, flag_b_o;

  always #10 clk = ~clk;

  pos_counter u_dut (.*, .clk_i(clk));

  typedef struct {
    string       req;
    int          kind;
    logic [31:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  int       pending = 0;
  int       n_cmp = 0, n_bad = 0;
  bit       finished = 0;

  // monitor: pops an expectation and compares against the port it names
  initial forever begin
    sb_item_t    it;
    logic [31:0] got;
    wait (pending > 0);
    it  = sb_q.pop_front();
    got = '0;
    case (it.kind)
      0: for (int b = 0; b < 3; b++) begin
           latch_byte_i = 2'(b);
           #1;
           got[b*8 +: 8] = latch_data_o;
         end
      1: got = {24'h0, status_o};
      2: got = {31'h0, flag_a_o};
      default: got = {31'h0, flag_b_o};
    endcase
    n_cmp++;
    if (got !== it.exp) begin
      n_bad++;
      $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
    end
    pending--;
  end

  task automatic chk(input string req, input int kind, input logic [31:0] exp);
    sb_item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
    pending++;
    wait (pending == 0);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic up);
    cnt_pulse_i = 1; cnt_up_i = up; tick(); cnt_pulse_i = 0;
  endtask

  task automatic wr_preset(input logic [23:0] v);
    for (int b = 0; b < 3; b++) begin
      preset_we_i = 1; preset_byte_i = 2'(b); preset_data_i = v[b*8 +: 8];
      tick();
    end
    preset_we_i = 0;
  endtask

  task automatic do_load();   cmd_load_cnt_i = 1;   tick(); cmd_load_cnt_i = 0;   endtask
  task automatic do_clr();    cmd_clr_cnt_i = 1;    tick(); cmd_clr_cnt_i = 0;    endtask
  task automatic do_clr_st(); cmd_clr_status_i = 1; tick(); cmd_clr_status_i = 0; endtask

  task automatic chk_cnt(input string req, input logic [23:0] exp);
    cmd_latch_i = 1; tick(); cmd_latch_i = 0;
    chk(req, 0, {8'h0, exp});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4_000_000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1;
    tick();

    // R1 reset state
    chk("R1 status", 1, 32'h10);
    chk("R1 flag_a", 2, 1);
    chk("R1 flag_b", 3, 1);
    chk_cnt("R1 count", 24'h0);

    // R2 preset bytes, load, snapshot while counting
    wr_preset(24'h123456);
    do_load();
    chk_cnt("R2 load", 24'h123456);
    cnt_pulse_i = 1; cnt_up_i = 1; cmd_latch_i = 1; tick();
    cnt_pulse_i = 0; cmd_latch_i = 0;
    chk("R2 snapshot old value", 0, 32'h123456);
    chk_cnt("R2 count kept going", 24'h123457);

    // R4 compare both directions, R8 latched flag and clear
    wr_preset(24'h123459);
    cfg_flag_sel_i = 4'b0100;
    pulse(1); pulse(1);
    chk("R4 compare up", 1, 32'h34);
    chk("R8 latched flag low", 2, 0);
    do_clr_st();
    chk("R8 cleared flag", 2, 1);
    chk("R8 cleared status", 1, 32'h30);
    pulse(1); pulse(0);
    chk("R4 compare down", 1, 32'h14);
    do_clr_st();

    // R3 wrap, sign, R10 second flag
    do_clr();
    cfg_flagb_sel_i = 2'b01;
    pulse(0);
    chk("R3 borrow and sign", 1, 32'h52);
    chk("R10 flag_b sign", 3, 1);
    chk_cnt("R3 wrap down", 24'hFFFFFF);
    pulse(1);
    chk("R3 carry clears sign", 1, 32'h33);
    chk("R10 flag_b positive", 3, 0);
    cfg_flagb_sel_i = 2'b10; tick();
    chk("R10 flag_b direction", 3, 1);

    // R8 pulse flag on carry
    do_clr_st();
    cfg_flag_sel_i = 4'b0001; cfg_flag_pulse_i = 1;
    pulse(0);
    chk("R8 unselected borrow", 2, 1);
    pulse(1);
    chk("R8 carry pulse low", 2, 0);
    tick();
    chk("R8 carry pulse ends", 2, 1);
    cfg_flag_pulse_i = 0; tick();
    chk("R8 latched carry", 2, 0);
    do_clr_st();

    // R5 single cycle
    cfg_mode_i = 2'b01;
    wr_preset(24'hFFFFFE);
    do_load();
    pulse(1); pulse(1);
    chk("R5 stopped after carry", 1, 32'h21);
    pulse(1);
    chk_cnt("R5 no count when stopped", 24'h0);
    do_load();
    chk("R5 load restarts", 1, 32'h31);
    chk_cnt("R5 loaded", 24'hFFFFFE);
    do_clr_st(); do_clr();
    pulse(0);
    chk("R5 stopped after borrow", 1, 32'h42);
    do_clr();
    chk("R5 clear restarts", 1, 32'h12);

    // R6 range limit, R9 pulse-only compare
    do_clr_st();
    cfg_mode_i = 2'b10; cfg_flag_sel_i = 4'b0110;
    wr_preset(24'h3);
    do_clr();
    pulse(1); pulse(1); pulse(1);
    chk("R9 compare pulse in range mode", 2, 0);
    tick();
    chk("R9 compare not latched", 2, 1);
    pulse(1); pulse(1);
    chk_cnt("R6 hold at preset", 24'h3);
    repeat (4) pulse(0);
    chk_cnt("R6 hold at zero", 24'h0);
    pulse(1);
    chk_cnt("R6 resume", 24'h1);

    // R7 modulo-n
    cfg_mode_i = 2'b11;
    do_clr();
    repeat (4) pulse(1);
    chk_cnt("R7 wrap up", 24'h0);
    do_clr_st();
    pulse(0);
    chk("R7 borrow", 1, 32'h12);
    chk_cnt("R7 reload down", 24'h3);

    // R11 index
    cfg_mode_i = 2'b00; cfg_flag_sel_i = 4'b0000;
    do_clr_st();
    wr_preset(24'h7);
    cfg_idx_fn_i = 2'b01;
    index_i = 1; tick(); tick();
    chk_cnt("R11 index load", 24'h7);
    cfg_idx_fn_i = 2'b10; tick();
    chk_cnt("R11 held level acts once", 24'h7);
    index_i = 0; tick(); index_i = 1; tick();
    chk_cnt("R11 index clear", 24'h0);
    chk("R11 index status", 1, 32'h18);
    cfg_idx_fn_i = 2'b11;
    index_i = 0;
    pulse(1); pulse(1);
    index_i = 1; tick();
    pulse(1);
    chk("R11 index snapshot", 0, 32'h2);
    cfg_idx_fn_i = 2'b00;
    index_i = 0; tick(); index_i = 1; tick();
    chk_cnt("R11 function off", 24'h3);

    // R12 freeze
    cfg_cnt_dis_i = 1; tick();
    chk("R12 enable bit low", 1, 32'h28);
    repeat (3) pulse(1);
    chk_cnt("R12 frozen", 24'h3);
    cfg_cnt_dis_i = 0;

    // R13 priority
    cmd_clr_cnt_i = 1; cmd_load_cnt_i = 1; cnt_pulse_i = 1; cnt_up_i = 1; tick();
    cmd_clr_cnt_i = 0; cmd_load_cnt_i = 0; cnt_pulse_i = 0;
    chk_cnt("R13 clear wins", 24'h0);
    cmd_load_cnt_i = 1; cnt_pulse_i = 1; tick();
    cmd_load_cnt_i = 0; cnt_pulse_i = 0;
    chk_cnt("R13 load beats pulse", 24'h7);

    finished = 1;
    summary();
    $finish;
  end
endmodule